// File: doc/BRIEF.md
# PCM Time-Slot Serial Port

This block is the digital serial side of a telephony voice codec. It moves one 8-bit encoded sample out and one 8-bit sample in per 8 kHz frame. On the transmit side, a frame sync pulse opens a time slot. The slot is timed by the transmit bit clock. The sample offered by the encoder is latched when the slot opens and shifted out MSB first. The serial data pin is driven only inside that slot. A low-active slot strobe marks the slot so that board logic or a line card can tell when the encoder owns the bus.

On the receive side, a receive frame sync arms a capture. The next eight falling edges of the receive bit clock sample the data pin MSB first. The finished word is handed to the decoder with a one-cycle valid strobe.

All pins are sampled by the block clock, which is the transmit master clock. Each bit clock must therefore run at a quarter of that rate or slower. The receive master clock pin is watched for activity:
- While it toggles, the receive master clock is used.
- If it stays low, the transmit master clock is selected.
- If it stays high, the port powers down.

If the receive bit clock pin stays static, the port switches to a synchronous mode. In that mode the transmit bit clock also times the receive direction.

Top module: `pcm_slot_port`

## Requirements
- R1: A transmit slot opens on a rising edge of `bclk_tx` seen while `fs_tx` is high. From that edge `dx_oe` is 1 and `dx` carries bit 7 of the latched sample.
- R2: Each later rising edge of `bclk_tx` inside the slot presents the next lower bit on `dx`. Exactly 8 bits are sent, MSB first.
- R3: `slot_n` is 0 exactly while `dx_oe` is 1. On the rising edge after the 8th bit, `dx_oe` returns to 0 and `slot_n` returns to 1.
- R4: A receive capture is armed by a rising edge of the receive bit clock seen while `fs_rx` is high. `dr` is then sampled on each of the next 8 falling edges, MSB first, so the first sampled bit lands in `rx_sample[7]`.
- R5: When the 8th receive bit is taken, `rx_valid` is 1 for exactly one clock with the completed word on `rx_sample`.
- R6: When `mclk_rx` shows no edge for 16 consecutive clocks and rests low, `clk_src_tx` becomes 1. Any edge on `mclk_rx` returns it to 0, and so does a rest of fewer than 16 clocks.
- R7: When `mclk_rx` shows no edge for 16 consecutive clocks and rests high, `power_down` becomes 1. An edge on `mclk_rx` clears it within 3 clocks.
- R8: While `power_down` is 1, no transmit slot opens: `dx_oe` stays 0 and `slot_n` stays 1. No receive word completes, and the shift state is cleared, so the first frame after power-down is sent and received normally.
- R9: When `bclk_rx` shows no edge for 16 consecutive clocks, receive bits are timed by the edges of `bclk_tx` instead.
- R10: The transmit sample is latched when the slot opens. Changes on `tx_sample` during the slot do not alter the bits sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (transmit master clock) |
| rst | input | 1 | Synchronous active-high reset |
| mclk_rx | input | 1 | Receive master clock pin; a static level selects the clock source or power-down |
| bclk_tx | input | 1 | Transmit bit clock |
| bclk_rx | input | 1 | Receive bit clock; a static level selects the synchronous mode |
| fs_tx | input | 1 | Transmit frame sync |
| fs_rx | input | 1 | Receive frame sync |
| dr | input | 1 | Serial receive data |
| tx_sample | input | 8 | Encoded sample from the encoder |
| dx | output | 1 | Serial transmit data, valid while `dx_oe` is 1 |
| dx_oe | output | 1 | Pad enable for `dx`; 0 means the pin floats |
| slot_n | output | 1 | Time-slot strobe, low during the transmit slot; the pad pulls low only |
| rx_sample | output | 8 | Last completed receive word |
| rx_valid | output | 1 | One-clock strobe marking a new `rx_sample` |
| clk_src_tx | output | 1 | 1 when the transmit master clock is selected for all timing |
| power_down | output | 1 | 1 while the port is powered down |

## Verification
A wrong transmit bit counter or shift register shows on `dx` within one bit period as a wrong bit. It can also show as a slot that is too long or too short, which the edge of `dx_oe` exposes at the ninth rising edge. A slip in the receive counter shows as a missing, doubled or shifted `rx_sample` at the end of the frame. A faulty idle counter on `mclk_rx` or `bclk_rx` shows after about 16 clocks as the wrong source, a missed power-down, or a silent receive path in synchronous mode. Power-down leaks are caught on the very next clock through `dx_oe` and `slot_n`.

// File: rtl/pcm_slot_pkg.sv
package pcm_slot_pkg;
  localparam int unsigned PIN_MCLK_RX = 0;
  localparam int unsigned PIN_BCLK_TX = 1;
  localparam int unsigned PIN_BCLK_RX = 2;
  localparam int unsigned PIN_FS_TX   = 3;
  localparam int unsigned PIN_FS_RX   = 4;
  localparam int unsigned PIN_DR      = 5;
  localparam int unsigned PIN_COUNT   = 6;
endpackage

// File: rtl/pcm_edge_sync.sv
module pcm_edge_sync (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic s_q, d_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_q <= 1'b0;
      d_q <= 1'b0;
    end else begin
      s_q <= pin;
      d_q <= s_q;
    end
  end

  assign lvl  = s_q;
  assign rise = s_q & ~d_q;
  assign fall = ~s_q & d_q;
endmodule

// File: rtl/pcm_static_det.sv
module pcm_static_det #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic edge_seen,
  output logic is_static
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  logic [CW-1:0] idle_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_q    <= '0;
      is_static <= 1'b0;
    end else if (edge_seen) begin
      idle_q    <= '0;
      is_static <= 1'b0;
    end else begin
      if (idle_q != CW'(LIMIT)) idle_q <= idle_q + 1'b1;
      is_static <= (idle_q == CW'(LIMIT));
    end
  end

  AST_EDGE_CLEARS_STATIC: assert property (@(posedge clk) disable iff (rst)
    edge_seen |=> !is_static); // R6
endmodule

// File: rtl/pcm_tx_slot.sv
module pcm_tx_slot #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pd,
  input  logic         bclk_rise,
  input  logic         fs_lvl,
  input  logic [W-1:0] sample,
  output logic         dx,
  output logic         dx_oe,
  output logic         slot_n
);
  localparam int unsigned CW = $clog2(W + 1);
  logic [W-1:0]  sh_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || pd) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      dx     <= 1'b0;
      dx_oe  <= 1'b0;
      slot_n <= 1'b1;
    end else if (bclk_rise) begin
      if (dx_oe) begin
        if (cnt_q == CW'(W - 1)) begin
          dx_oe  <= 1'b0;
          slot_n <= 1'b1;
          dx     <= 1'b0;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
          sh_q  <= sh_q << 1;
          dx    <= sh_q[W-2];
        end
      end else if (fs_lvl) begin
        sh_q   <= sample;
        dx     <= sample[W-1];
        cnt_q  <= '0;
        dx_oe  <= 1'b1;
        slot_n <= 1'b0;
      end
    end
  end

  AST_SLOT_NEEDS_FS: assert property (@(posedge clk) disable iff (rst)
    $rose(dx_oe) |-> $past(fs_lvl && bclk_rise)); // R1
  AST_DX_MOVES_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    (!bclk_rise && !pd) |=> $stable(dx)); // R2
  AST_PD_SILENCES_TX: assert property (@(posedge clk) disable iff (rst)
    pd |=> (!dx_oe && slot_n)); // R8
endmodule

// File: rtl/pcm_rx_slot.sv
module pcm_rx_slot #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pd,
  input  logic         bclk_rise,
  input  logic         bclk_fall,
  input  logic         fs_lvl,
  input  logic         dr_lvl,
  output logic [W-1:0] rx_sample,
  output logic         rx_valid
);
  localparam int unsigned CW = $clog2(W + 1);
  logic [W-1:0]  sh_q;
  logic [CW-1:0] cnt_q;
  logic          armed_q;

  always_ff @(posedge clk) begin
    if (rst || pd) begin
      sh_q      <= '0;
      cnt_q     <= '0;
      armed_q   <= 1'b0;
      rx_valid  <= 1'b0;
      rx_sample <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (!armed_q && bclk_rise && fs_lvl) begin
        armed_q <= 1'b1;
        cnt_q   <= '0;
      end else if (armed_q && bclk_fall) begin
        sh_q <= {sh_q[W-2:0], dr_lvl};
        if (cnt_q == CW'(W - 1)) begin
          rx_sample <= {sh_q[W-2:0], dr_lvl};
          rx_valid  <= 1'b1;
          armed_q   <= 1'b0;
          cnt_q     <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid); // R5
  AST_VALID_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> $past(bclk_fall)); // R4
endmodule

// File: rtl/pcm_slot_port.sv
module pcm_slot_port #(
  parameter int unsigned W          = 8,
  parameter int unsigned IDLE_LIMIT = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mclk_rx,
  input  logic         bclk_tx,
  input  logic         bclk_rx,
  input  logic         fs_tx,
  input  logic         fs_rx,
  input  logic         dr,
  input  logic [W-1:0] tx_sample,
  output logic         dx,
  output logic         dx_oe,
  output logic         slot_n,
  output logic [W-1:0] rx_sample,
  output logic         rx_valid,
  output logic         clk_src_tx,
  output logic         power_down
);
  import pcm_slot_pkg::*;

  logic [PIN_COUNT-1:0] pin_raw, pin_lvl, pin_rise, pin_fall;
  logic mclk_static, bclk_rx_static;
  logic rx_rise, rx_fall;

  assign pin_raw[PIN_MCLK_RX] = mclk_rx;
  assign pin_raw[PIN_BCLK_TX] = bclk_tx;
  assign pin_raw[PIN_BCLK_RX] = bclk_rx;
  assign pin_raw[PIN_FS_TX]   = fs_tx;
  assign pin_raw[PIN_FS_RX]   = fs_rx;
  assign pin_raw[PIN_DR]      = dr;

  for (genvar i = 0; i < PIN_COUNT; i++) begin : g_pin
    pcm_edge_sync u_sync (
      .clk (clk),
      .rst (rst),
      .pin (pin_raw[i]),
      .lvl (pin_lvl[i]),
      .rise(pin_rise[i]),
      .fall(pin_fall[i])
    );
  end

  pcm_static_det #(.LIMIT(IDLE_LIMIT)) u_mclk_det (
    .clk      (clk),
    .rst      (rst),
    .edge_seen(pin_rise[PIN_MCLK_RX] | pin_fall[PIN_MCLK_RX]),
    .is_static(mclk_static)
  );

  pcm_static_det #(.LIMIT(IDLE_LIMIT)) u_bclk_det (
    .clk      (clk),
    .rst      (rst),
    .edge_seen(pin_rise[PIN_BCLK_RX] | pin_fall[PIN_BCLK_RX]),
    .is_static(bclk_rx_static)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      power_down <= 1'b0;
      clk_src_tx <= 1'b0;
    end else begin
      power_down <= mclk_static &  pin_lvl[PIN_MCLK_RX];
      clk_src_tx <= mclk_static & ~pin_lvl[PIN_MCLK_RX];
    end
  end

  assign rx_rise = bclk_rx_static ? pin_rise[PIN_BCLK_TX] : pin_rise[PIN_BCLK_RX];
  assign rx_fall = bclk_rx_static ? pin_fall[PIN_BCLK_TX] : pin_fall[PIN_BCLK_RX];

  logic unused_pins;
  assign unused_pins = ^{pin_fall[PIN_FS_TX], pin_fall[PIN_FS_RX], pin_fall[PIN_DR],
                         pin_rise[PIN_FS_TX], pin_rise[PIN_FS_RX], pin_rise[PIN_DR],
                         pin_lvl[PIN_BCLK_TX], pin_lvl[PIN_BCLK_RX]};

  pcm_tx_slot #(.W(W)) u_tx (
    .clk      (clk),
    .rst      (rst),
    .pd       (power_down),
    .bclk_rise(pin_rise[PIN_BCLK_TX]),
    .fs_lvl   (pin_lvl[PIN_FS_TX]),
    .sample   (tx_sample),
    .dx       (dx),
    .dx_oe    (dx_oe),
    .slot_n   (slot_n)
  );

  pcm_rx_slot #(.W(W)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .pd       (power_down),
    .bclk_rise(rx_rise),
    .bclk_fall(rx_fall),
    .fs_lvl   (pin_lvl[PIN_FS_RX]),
    .dr_lvl   (pin_lvl[PIN_DR]),
    .rx_sample(rx_sample),
    .rx_valid (rx_valid)
  );

  AST_SRC_OR_PD: assert property (@(posedge clk) disable iff (rst)
    !(power_down && clk_src_tx)); // R7
endmodule

// File: tb/sim_pcm_slot_port.sv
`timescale 1ns/1ps
module sim_pcm_slot_port;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mclk_rx = 1'b0, bclk_tx = 1'b0, bclk_rx = 1'b0;
  logic fs_tx = 1'b0, fs_rx = 1'b0, dr = 1'b0;
  logic [7:0] tx_sample = 8'h00;
  logic dx, dx_oe, slot_n, rx_valid, clk_src_tx, power_down;
  logic [7:0] rx_sample;

  int checks = 0;
  int errors = 0;
  int mclk_mode = 0;
  int vcount = 0;
  logic [7:0] vword = 8'h00;
  logic prev_v = 1'b0;
  logic run_chk = 1'b0;

  always #10 clk = ~clk;

  pcm_slot_port u0 (
    .clk(clk), .rst(rst), .mclk_rx(mclk_rx), .bclk_tx(bclk_tx), .bclk_rx(bclk_rx),
    .fs_tx(fs_tx), .fs_rx(fs_rx), .dr(dr), .tx_sample(tx_sample),
    .dx(dx), .dx_oe(dx_oe), .slot_n(slot_n), .rx_sample(rx_sample),
    .rx_valid(rx_valid), .clk_src_tx(clk_src_tx), .power_down(power_down)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  int mc_div = 0;
  always @(negedge clk) begin
    if (mclk_mode == 0) begin
      mc_div++;
      if (mc_div == 2) begin mclk_rx <= ~mclk_rx; mc_div = 0; end
    end else if (mclk_mode == 1) mclk_rx <= 1'b0;
    else mclk_rx <= 1'b1;
  end

  always @(negedge clk) begin
    if (rx_valid) begin vcount++; vword = rx_sample; end
    if (run_chk) begin
      chk(dx_oe == !slot_n, "R3 strobe/enable pair", dx_oe, !slot_n);
      if (rx_valid && prev_v) chk(0, "R5 valid width", 2, 1);
      if (power_down) chk(!dx_oe, "R8 no slot in power-down", dx_oe, 0);
    end
    prev_v = rx_valid;
  end

  task automatic frame(input logic [7:0] tv, input logic [7:0] rv,
                       input bit use_sync, input bit pd_exp);
    int v0;
    v0 = vcount;
    tx_sample = tv;
    @(negedge clk); fs_tx = 1'b1; fs_rx = 1'b1;
    repeat (7) @(negedge clk);
    for (int k = 0; k <= 8; k++) begin
      @(negedge clk);
      bclk_tx = 1'b1;
      if (!use_sync) bclk_rx = 1'b1;
      dr = (k < 8) ? rv[7-k] : 1'b0;
      repeat (5) @(negedge clk);
      if (pd_exp) begin
        chk(!dx_oe && slot_n, "R8 slot held off", {dx_oe, slot_n}, 1);
      end else if (k < 8) begin
        chk(dx_oe == 1'b1, "R1 slot enable", dx_oe, 1);
        chk(slot_n == 1'b0, "R3 strobe low in slot", slot_n, 0);
        chk(dx == tv[7-k], "R2 bit order", dx, tv[7-k]);
      end else begin
        chk(dx_oe == 1'b0 && slot_n == 1'b1, "R3 slot closes after 8 bits",
            {dx_oe, slot_n}, 1);
      end
      if (k == 0) tx_sample = ~tv; // R10: later change must not reach dx
      repeat (2) @(negedge clk);
      if (k == 0) begin fs_tx = 1'b0; fs_rx = 1'b0; end
      @(negedge clk);
      bclk_tx = 1'b0;
      if (!use_sync) bclk_rx = 1'b0;
      repeat (7) @(negedge clk);
    end
    if (pd_exp) begin
      chk(vcount == v0, "R8 no receive word", vcount - v0, 0);
    end else begin
      chk(vcount == v0 + 1, "R5 one valid per frame", vcount - v0, 1);
      chk(vword == rv, use_sync ? "R9 sync-mode word" : "R4 receive word", vword, rv);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(dx_oe == 0 && slot_n == 1 && rx_valid == 0, "R3 reset state",
        {dx_oe, slot_n, rx_valid}, 3'b010);
    chk(power_down == 0 && clk_src_tx == 0, "R6 reset source", {power_down, clk_src_tx}, 0);
    run_chk = 1'b1;

    frame(8'hA5, 8'h3C, 0, 0);
    frame(8'h80, 8'h01, 0, 0);
    frame(8'hFF, 8'h00, 0, 0);
    frame(8'h00, 8'hFF, 0, 0);
    chk(clk_src_tx == 0 && power_down == 0, "R6 toggling uses rx clock",
        {power_down, clk_src_tx}, 0);

    mclk_mode = 1;
    repeat (10) @(negedge clk);
    chk(clk_src_tx == 0, "R6 short rest not static", clk_src_tx, 0);
    repeat (30) @(negedge clk);
    chk(clk_src_tx == 1 && power_down == 0, "R6 static low selects tx clock",
        {power_down, clk_src_tx}, 1);
    frame(8'h5A, 8'hC3, 0, 0);
    mclk_mode = 0;
    repeat (6) @(negedge clk);
    chk(clk_src_tx == 0, "R6 edge returns to rx clock", clk_src_tx, 0);

    mclk_mode = 2;
    repeat (40) @(negedge clk);
    chk(power_down == 1 && clk_src_tx == 0, "R7 static high powers down",
        {power_down, clk_src_tx}, 2);
    frame(8'hE7, 8'h81, 0, 1);
    mclk_mode = 0;
    repeat (6) @(negedge clk);
    chk(power_down == 0, "R7 power-down exit", power_down, 0);
    frame(8'h69, 8'h96, 0, 0); // R8 normal after exit

    bclk_rx = 1'b1;
    repeat (40) @(negedge clk);
    frame(8'h12, 8'hB4, 1, 0);
    bclk_rx = 1'b0;
    repeat (40) @(negedge clk);
    frame(8'h7E, 8'h4D, 1, 0);

    run_chk = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule